// File: doc/BRIEF.md
# DRAM Idle Low-Power Sequencer

This block sits beside a DRAM controller and watches a single bus-idle indication, sampled on the DFI clock (half the DRAM clock rate). A counter tracks how many consecutive DFI cycles the bus has been idle. Five configurable thresholds, some counted in single cycles and some in units of 1024 cycles, select progressively deeper low-power tiers. These run from simple power-down through self-refresh, self-refresh with the controller clock stopped, and self-refresh power-down (LPDDR4 parts only), to a full standby in which the controller, PHY and DRAM clocks are all stopped.

For each tier it enters, the block emits a one-cycle entry strobe together with the new state code, and it drives the clock-gate enables for that tier. When traffic returns, it first releases every clock gate. One cycle later it raises an exit request and holds it until the memory side acknowledges. Only then does it report the active state. The thresholds and the memory-type flag are captured into shadow registers, and those registers update only while the block is active. A write made in the middle of a low-power residency therefore cannot disturb it.

Top module: `dils_top`

## Requirements
- R1: While reset is held, and in the first cycle after it, `lp_state` is 0 and `enter_req`, `exit_req` and all three clock-gate outputs are low.
- R2: The idle counter counts consecutive cycles in which `bus_idle` is high. One cycle with `bus_idle` low restarts the count from zero, so interrupted idle periods never add up.
- R3: Power-down and standby limits are their threshold values in DFI cycles. The self-refresh, gated self-refresh and self-refresh power-down limits are their threshold values times 1024. A tier is reached once the count is at least its limit, and the state changes at the following clock edge.
- R4: A threshold of 0 disables its tier, which is then never entered whatever the idle time.
- R5: Among the reached tiers, the one with the highest code is chosen. While the bus stays idle in a low-power state, the block moves to a deeper tier as soon as one is reached and never moves to a shallower one.
- R6: Self-refresh power-down (code 4) is entered only when `dram_is_lp4` was captured as 1.
- R7: `lp_state` encodes 0 active, 1 power-down, 2 self-refresh, 3 self-refresh with controller clock gated, 4 self-refresh power-down, 5 standby. No other value appears.
- R8: While resident in a low-power state, code 3 raises only `ctrl_clk_gate`, and code 5 raises `ctrl_clk_gate`, `phy_clk_gate` and `dram_clk_gate`. The other codes raise none of them.
- R9: `enter_req` is high for exactly the cycle following each entry or deepening edge, and `lp_state` then shows the new code.
- R10: When `bus_idle` is seen low in a low-power state, all clock gates drop in the next cycle. `exit_req` rises one cycle later and stays high until `exit_done` is sampled high, and `lp_state` keeps the old code until then. It becomes 0 in the cycle after that sample. `exit_done` has no effect at any other time.
- R11: Threshold and memory-type inputs are captured only while the block is active. Changes made during a low-power residency or an exit take effect only after the return to active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_idle | input | 1 | High when the memory bus has no traffic this cycle |
| exit_done | input | 1 | Acknowledge that low-power exit has completed |
| dram_is_lp4 | input | 1 | Attached memory is LPDDR4 (enables code 4) |
| cfg_pd_idle | input | THR_W | Power-down threshold, unscaled cycles |
| cfg_sr_idle | input | THR_W | Self-refresh threshold, units of 1024 cycles |
| cfg_srcg_idle | input | THR_W | Self-refresh with controller clock gate threshold, units of 1024 cycles |
| cfg_srpd_idle | input | THR_W | Self-refresh power-down threshold, units of 1024 cycles |
| cfg_stby_idle | input | THR_W | Standby threshold, unscaled cycles |
| lp_state | output | 3 | Current low-power state code |
| enter_req | output | 1 | One-cycle strobe on entering or deepening a state |
| exit_req | output | 1 | Request to leave low power, held until acknowledged |
| ctrl_clk_gate | output | 1 | Stop the controller clock |
| phy_clk_gate | output | 1 | Stop the PHY clock |
| dram_clk_gate | output | 1 | Stop the DRAM clock |

## Verification
The assertions assume that the memory side raises `exit_done` at arbitrary times, including while no exit is pending. The design must therefore ignore it outside the wait for acknowledgement, and the stimulus toggles it at random in every phase. The assertions also assume that thresholds change at any cycle, so the random phase rewrites them on both sides of a low-power residency. Threshold values are drawn small enough that every tier, including the 1024-scaled ones, is reached within a single idle burst. Bursts are interrupted by short busy gaps of random length so that the count restarts.

// File: rtl/dils_pkg.sv
package dils_pkg;

  localparam int NUM_TIERS = 5;

  typedef enum logic [2:0] {
    LP_ACT  = 3'd0,
    LP_PD   = 3'd1,
    LP_SR   = 3'd2,
    LP_SRCG = 3'd3,
    LP_SRPD = 3'd4,
    LP_STBY = 3'd5
  } lp_mode_e;

  typedef enum logic [1:0] {
    PH_RUN,
    PH_LOW,
    PH_UNGATE,
    PH_WAKE
  } phase_e;

  // bit i set: tier i+1 counts in units of 2**SCALE_SH cycles
  localparam logic [NUM_TIERS-1:0] TIER_SCALED = 5'b01110;

  // cycle limit of a tier from its threshold
  function automatic longint unsigned tier_limit(longint unsigned thr, bit scaled, int sh);
    return scaled ? (thr << sh) : thr;
  endfunction

  // clock gates for a resident mode, packed {dram, phy, ctrl}
  function automatic logic [2:0] gate_map(lp_mode_e m);
    case (m)
      LP_SRCG: return 3'b001;
      LP_STBY: return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/dils_idle_cnt.sv
module dils_idle_cnt #(
  parameter int CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  output logic [CNT_W-1:0] idle_cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_cnt <= '0;
    end else if (!bus_idle) begin
      idle_cnt <= '0;
    end else if (idle_cnt != {CNT_W{1'b1}}) begin
      idle_cnt <= idle_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/dils_tier_sel.sv
module dils_tier_sel
  import dils_pkg::*;
#(
  parameter int THR_W    = 16,
  parameter int SCALE_SH = 10,
  parameter int CNT_W    = THR_W + SCALE_SH
) (
  input  logic [CNT_W-1:0]                idle_cnt,
  input  logic [NUM_TIERS-1:0][THR_W-1:0] thr,
  input  logic                            lp4,
  output lp_mode_e                        tgt
);

  localparam int SRPD_IDX = int'(LP_SRPD) - 1;

  logic [NUM_TIERS-1:0] reach;

  for (genvar i = 0; i < NUM_TIERS; i++) begin : g_tier
    logic allowed;
    if (i == SRPD_IDX) begin : g_lp4
      assign allowed = lp4;
    end else begin : g_any
      assign allowed = 1'b1;
    end
    assign reach[i] = allowed && (thr[i] != '0) &&
                      (64'(idle_cnt) >= tier_limit(64'(thr[i]), TIER_SCALED[i], SCALE_SH));
  end

  // highest reached code wins
  always_comb begin
    tgt = LP_ACT;
    for (int i = 0; i < NUM_TIERS; i++) begin
      if (reach[i]) tgt = lp_mode_e'(3'(i + 1));
    end
  end

endmodule

// File: rtl/dils_fsm.sv
module dils_fsm
  import dils_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bus_idle,
  input  logic     exit_done,
  input  lp_mode_e tgt,
  output lp_mode_e mode,
  output logic     enter_req,
  output logic     exit_req,
  output logic [2:0] gates,
  output logic     shadow_load
);

  phase_e phase;
  logic   go_low;

  assign go_low      = bus_idle && (tgt != LP_ACT);
  assign shadow_load = (phase == PH_RUN) && !go_low;
  assign exit_req    = (phase == PH_WAKE);
  assign gates       = (phase == PH_LOW) ? gate_map(mode) : 3'b000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_RUN;
      mode      <= LP_ACT;
      enter_req <= 1'b0;
    end else begin
      enter_req <= 1'b0;
      case (phase)
        PH_RUN: begin
          if (go_low) begin
            phase     <= PH_LOW;
            mode      <= tgt;
            enter_req <= 1'b1;
          end
        end
        PH_LOW: begin
          if (!bus_idle) begin
            phase <= PH_UNGATE;
          end else if (tgt > mode) begin
            mode      <= tgt;
            enter_req <= 1'b1;
          end
        end
        PH_UNGATE: phase <= PH_WAKE;
        PH_WAKE: begin
          if (exit_done) begin
            phase <= PH_RUN;
            mode  <= LP_ACT;
          end
        end
        default: phase <= PH_RUN;
      endcase
    end
  end

endmodule

// File: rtl/dils_top.sv
module dils_top
  import dils_pkg::*;
#(
  parameter int THR_W    = 16,
  parameter int SCALE_SH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_idle,
  input  logic             exit_done,
  input  logic             dram_is_lp4,
  input  logic [THR_W-1:0] cfg_pd_idle,
  input  logic [THR_W-1:0] cfg_sr_idle,
  input  logic [THR_W-1:0] cfg_srcg_idle,
  input  logic [THR_W-1:0] cfg_srpd_idle,
  input  logic [THR_W-1:0] cfg_stby_idle,
  output logic [2:0]       lp_state,
  output logic             enter_req,
  output logic             exit_req,
  output logic             ctrl_clk_gate,
  output logic             phy_clk_gate,
  output logic             dram_clk_gate
);

  localparam int CNT_W = THR_W + SCALE_SH;

  logic [CNT_W-1:0]                idle_cnt;
  logic [NUM_TIERS-1:0][THR_W-1:0] cfg_thr;
  logic [NUM_TIERS-1:0][THR_W-1:0] sh_thr;
  logic                            sh_lp4;
  logic                            shadow_load;
  lp_mode_e                        tgt;
  lp_mode_e                        mode;
  logic [2:0]                      gates;

  assign cfg_thr = {cfg_stby_idle, cfg_srpd_idle, cfg_srcg_idle, cfg_sr_idle, cfg_pd_idle};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_thr <= '0;
      sh_lp4 <= 1'b0;
    end else if (shadow_load) begin
      sh_thr <= cfg_thr;
      sh_lp4 <= dram_is_lp4;
    end
  end

  dils_idle_cnt #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_idle (bus_idle),
    .idle_cnt (idle_cnt)
  );

  dils_tier_sel #(.THR_W(THR_W), .SCALE_SH(SCALE_SH), .CNT_W(CNT_W)) sel_i (
    .idle_cnt (idle_cnt),
    .thr      (sh_thr),
    .lp4      (sh_lp4),
    .tgt      (tgt)
  );

  dils_fsm fsm_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_idle    (bus_idle),
    .exit_done   (exit_done),
    .tgt         (tgt),
    .mode        (mode),
    .enter_req   (enter_req),
    .exit_req    (exit_req),
    .gates       (gates),
    .shadow_load (shadow_load)
  );

  assign lp_state      = 3'(mode);
  assign ctrl_clk_gate = gates[0];
  assign phy_clk_gate  = gates[1];
  assign dram_clk_gate = gates[2];

endmodule

// File: rtl/dils_chk.sv
module dils_chk #(
  parameter int THR_W = 16,
  parameter int CNT_W = 26
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_idle,
  input logic                  exit_done,
  input logic [2:0]            lp_state,
  input logic                  enter_req,
  input logic                  exit_req,
  input logic                  ctrl_clk_gate,
  input logic                  phy_clk_gate,
  input logic                  dram_clk_gate,
  input logic [CNT_W-1:0]      idle_cnt,
  input logic [5*THR_W-1:0]    sh_thr_flat,
  input logic                  sh_lp4
);

  function automatic logic [THR_W-1:0] thr_for(logic [2:0] m);
    case (m)
      3'd1:    return sh_thr_flat[0*THR_W +: THR_W];
      3'd2:    return sh_thr_flat[1*THR_W +: THR_W];
      3'd3:    return sh_thr_flat[2*THR_W +: THR_W];
      3'd4:    return sh_thr_flat[3*THR_W +: THR_W];
      3'd5:    return sh_thr_flat[4*THR_W +: THR_W];
      default: return '0;
    endcase
  endfunction

  assert_code_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lp_state <= 3'd5);

  assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_idle |=> (idle_cnt == '0));

  assert_zero_tier_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> (thr_for(lp_state) != '0));

  assert_lp4_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_req && lp_state == 3'd4) |-> sh_lp4);

  assert_no_shallower_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_state) != 3'd0 && lp_state != 3'd0) |-> (lp_state >= $past(lp_state)));

  assert_gate_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dram_clk_gate |-> (lp_state == 3'd5 && phy_clk_gate && ctrl_clk_gate));

  assert_enter_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_req |-> (lp_state != 3'd0));

  assert_gates_before_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    exit_req |-> !(ctrl_clk_gate || phy_clk_gate || dram_clk_gate));

  assert_wake_needs_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state == 3'd0 && $past(lp_state) != 3'd0) |-> $past(exit_done && exit_req));

  assert_cfg_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lp_state) != 3'd0 && lp_state != 3'd0) |-> $stable(sh_thr_flat));

endmodule

bind dils_top dils_chk #(.THR_W(THR_W), .CNT_W(THR_W + SCALE_SH)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_idle      (bus_idle),
  .exit_done     (exit_done),
  .lp_state      (lp_state),
  .enter_req     (enter_req),
  .exit_req      (exit_req),
  .ctrl_clk_gate (ctrl_clk_gate),
  .phy_clk_gate  (phy_clk_gate),
  .dram_clk_gate (dram_clk_gate),
  .idle_cnt      (idle_cnt),
  .sh_thr_flat   (sh_thr),
  .sh_lp4        (sh_lp4)
);

// File: tb/dils_top_tb_top.sv
module dils_top_tb_top;

  localparam int THR_W = 16;
  localparam int CNT_MAX = (1 << 26) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_idle = 1'b0;
  logic exit_done = 1'b0;
  logic dram_is_lp4 = 1'b0;
  logic [THR_W-1:0] c_pd = '0, c_sr = '0, c_cg = '0, c_srpd = '0, c_sb = '0;
  logic [2:0] lp_state;
  logic enter_req, exit_req, ctrl_clk_gate, phy_clk_gate, dram_clk_gate;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit live_cmp = 1'b0;

  always #10 clk = ~clk;

  dils_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_idle(bus_idle), .exit_done(exit_done),
    .dram_is_lp4(dram_is_lp4), .cfg_pd_idle(c_pd), .cfg_sr_idle(c_sr),
    .cfg_srcg_idle(c_cg), .cfg_srpd_idle(c_srpd), .cfg_stby_idle(c_sb),
    .lp_state(lp_state), .enter_req(enter_req), .exit_req(exit_req),
    .ctrl_clk_gate(ctrl_clk_gate), .phy_clk_gate(phy_clk_gate),
    .dram_clk_gate(dram_clk_gate)
  );

  // reference model: phases 0 run, 1 resident, 2 ungating, 3 waiting ack
  int m_cnt, m_ph, m_mode;
  bit m_enter;
  int m_sh[5];
  bit m_lp4;

  function automatic int lim_of(int i, int thr);
    return (i >= 1 && i <= 3) ? thr * 1024 : thr;
  endfunction

  function automatic logic [2:0] exp_gates(int ph, int mode);
    if (ph != 1) return 3'b000;
    if (mode == 3) return 3'b001;
    if (mode == 5) return 3'b111;
    return 3'b000;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    int tgt, ncnt;
    bit ld;
    if (!rst_n) begin
      m_cnt = 0; m_ph = 0; m_mode = 0; m_enter = 0; m_lp4 = 0;
      for (int i = 0; i < 5; i++) m_sh[i] = 0;
    end else begin
      tgt = 0;
      for (int i = 0; i < 5; i++)
        if (m_sh[i] != 0 && m_cnt >= lim_of(i, m_sh[i]) && (i != 3 || m_lp4)) tgt = i + 1;
      ncnt = bus_idle ? ((m_cnt < CNT_MAX) ? m_cnt + 1 : m_cnt) : 0;
      ld = (m_ph == 0) && !(bus_idle && tgt != 0);
      m_enter = 0;
      case (m_ph)
        0: if (bus_idle && tgt != 0) begin m_ph = 1; m_mode = tgt; m_enter = 1; end
        1: if (!bus_idle) m_ph = 2;
           else if (tgt > m_mode) begin m_mode = tgt; m_enter = 1; end
        2: m_ph = 3;
        default: if (exit_done) begin m_ph = 0; m_mode = 0; end
      endcase
      if (ld) begin
        m_sh[0] = int'(c_pd); m_sh[1] = int'(c_sr); m_sh[2] = int'(c_cg);
        m_sh[3] = int'(c_srpd); m_sh[4] = int'(c_sb); m_lp4 = dram_is_lp4;
      end
      m_cnt = ncnt;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    cycles++;
    if (rst_n && live_cmp) begin
      chk(int'(lp_state) == m_mode, "R5 state", int'(lp_state), m_mode);
      chk({dram_clk_gate, phy_clk_gate, ctrl_clk_gate} == exp_gates(m_ph, m_mode),
          "R8 gates", int'({dram_clk_gate, phy_clk_gate, ctrl_clk_gate}),
          int'(exp_gates(m_ph, m_mode)));
      chk(exit_req == (m_ph == 3), "R10 exit_req", int'(exit_req), int'(m_ph == 3));
      chk(enter_req == m_enter, "R9 enter_req", int'(enter_req), int'(m_enter));
    end
  end

  task automatic set_cfg(input int pd, input int sr, input int cg, input int srpd,
                         input int sb, input bit lp4);
    c_pd = THR_W'(pd); c_sr = THR_W'(sr); c_cg = THR_W'(cg);
    c_srpd = THR_W'(srpd); c_sb = THR_W'(sb); dram_is_lp4 = lp4;
  endtask

  task automatic go_active();
    bus_idle = 1'b0; exit_done = 1'b1;
    repeat (4) @(negedge clk);
    exit_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic idle_n(input int n);
    bus_idle = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic rand_step(input bit bi);
    bus_idle = bi;
    exit_done = (($urandom % 3) == 0);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    @(negedge clk);
    chk(lp_state == 3'd0 && !enter_req && !exit_req &&
        !ctrl_clk_gate && !phy_clk_gate && !dram_clk_gate, "R1 in reset",
        int'(lp_state), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lp_state == 3'd0 && !enter_req && !exit_req &&
        !ctrl_clk_gate && !phy_clk_gate && !dram_clk_gate, "R1 after reset",
        int'(lp_state), 0);
    live_cmp = 1'b1;

    // R3 unscaled power-down limit
    set_cfg(5, 0, 0, 0, 0, 0); go_active();
    idle_n(5); chk(lp_state == 3'd0, "R3 pd early", int'(lp_state), 0);
    idle_n(1); chk(lp_state == 3'd1, "R3 pd entry", int'(lp_state), 1);
    chk(enter_req == 1'b1, "R9 strobe", int'(enter_req), 1);
    idle_n(1); chk(enter_req == 1'b0, "R9 one cycle", int'(enter_req), 0);

    // R2 interrupted idle does not accumulate
    set_cfg(8, 0, 0, 0, 0, 0); go_active();
    idle_n(7); bus_idle = 1'b0; @(negedge clk);
    idle_n(8); chk(lp_state == 3'd0, "R2 restart", int'(lp_state), 0);
    idle_n(1); chk(lp_state == 3'd1, "R2 full run", int'(lp_state), 1);

    // R3 scaled self-refresh limit
    set_cfg(0, 1, 0, 0, 0, 0); go_active();
    idle_n(1024); chk(lp_state == 3'd0, "R3 sr early", int'(lp_state), 0);
    idle_n(1); chk(lp_state == 3'd2, "R3 sr entry", int'(lp_state), 2);

    // R7 / R8 gated self-refresh
    set_cfg(0, 0, 1, 0, 0, 0); go_active();
    idle_n(1025); chk(lp_state == 3'd3, "R7 code 3", int'(lp_state), 3);
    chk(ctrl_clk_gate && !phy_clk_gate && !dram_clk_gate, "R8 ctrl only",
        int'({dram_clk_gate, phy_clk_gate, ctrl_clk_gate}), 1);

    // R7 / R8 standby
    set_cfg(0, 0, 0, 0, 10, 0); go_active();
    idle_n(11); chk(lp_state == 3'd5, "R7 code 5", int'(lp_state), 5);
    chk(ctrl_clk_gate && phy_clk_gate && dram_clk_gate, "R8 all gates",
        int'({dram_clk_gate, phy_clk_gate, ctrl_clk_gate}), 7);

    // R10 exit ordering from standby
    bus_idle = 1'b0; exit_done = 1'b0; @(negedge clk);
    chk(!ctrl_clk_gate && !phy_clk_gate && !dram_clk_gate && !exit_req,
        "R10 gates drop first", int'({exit_req, dram_clk_gate, phy_clk_gate, ctrl_clk_gate}), 0);
    @(negedge clk); chk(exit_req == 1'b1, "R10 exit_req rises", int'(exit_req), 1);
    repeat (3) @(negedge clk);
    chk(exit_req && lp_state == 3'd5, "R10 hold until ack", int'(lp_state), 5);
    exit_done = 1'b1; @(negedge clk); exit_done = 1'b0;
    chk(lp_state == 3'd0 && !exit_req, "R10 active after ack", int'(lp_state), 0);

    // R6 srpd needs lpddr4
    set_cfg(0, 0, 0, 1, 0, 0); go_active();
    idle_n(1100); chk(lp_state == 3'd0, "R6 not lp4", int'(lp_state), 0);
    set_cfg(0, 0, 0, 1, 0, 1); go_active();
    idle_n(1025); chk(lp_state == 3'd4, "R6 lp4 entry", int'(lp_state), 4);

    // R4 all tiers disabled
    set_cfg(0, 0, 0, 0, 0, 1); go_active();
    idle_n(3000); chk(lp_state == 3'd0, "R4 disabled", int'(lp_state), 0);

    // R5 deepening
    set_cfg(3, 1, 0, 0, 0, 0); go_active();
    idle_n(4); chk(lp_state == 3'd1, "R5 first tier", int'(lp_state), 1);
    idle_n(1021); chk(lp_state == 3'd2, "R5 deepen", int'(lp_state), 2);

    // R11 config frozen while in low power
    set_cfg(5, 0, 0, 0, 0, 0); go_active();
    idle_n(6); chk(lp_state == 3'd1, "R11 base", int'(lp_state), 1);
    set_cfg(5, 0, 0, 0, 20, 0);
    idle_n(50); chk(lp_state == 3'd1, "R11 ignored in lp", int'(lp_state), 1);
    go_active();
    idle_n(21); chk(lp_state == 3'd5, "R11 applied after wake", int'(lp_state), 5);

    // random phase
    go_active();
    for (int k = 0; k < 30; k++) begin
      if (($urandom % 2) == 0)
        set_cfg($urandom % 40, $urandom % 3, $urandom % 3, $urandom % 3,
                $urandom % 3000, 1'($urandom % 2));
      begin
        int run = $urandom % 3500;
        for (int j = 0; j < run; j++) rand_step(1'b1);
      end
      begin
        int gap = ($urandom % 20) + 1;
        for (int j = 0; j < gap; j++) rand_step(1'b0);
      end
    end
    go_active();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 190000);
    errors++;
    checks++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule